// File: doc/BRIEF.md
# Edge-Triggered Interrupt Entry and Return Unit

This unit sits next to the control sequencer of a small multi-cycle processor and looks after a single external interrupt line. The line is asynchronous to the core. It passes through a synchronizer, and a low-to-high transition on it sets a pending flag. The flag stays set until the sequencer signals the end of an instruction. At that boundary the unit raises a pending indication. If the sequencer accepts it, the unit does three things in that cycle. It records the address of the instruction that would have run next. It steers the program-counter multiplexer to the service-routine address, which is held in a vector register. It clears the flag.

While the routine runs, an in-service bit blocks any further entry. A return command then steers the program-counter multiplexer to the recorded address, and the interrupted program continues with the instruction after the one it was executing. Each event has one entry and one return. There is no nesting and there is no priority scheme.

Top module: `irq_unit`

## Requirements
- R1: After synchronous reset, `irq_pending_o` and `in_service_o` are 0, `pc_sel_o` is 0 (normal next PC), `target_pc_o` is 0, the saved return address is 0, and the vector register holds its default value 16'h0F80.
- R2: A request is raised only by a low-to-high transition of `irq_req_i`. The pending indication can first be seen after the third rising clock edge at which the pin is sampled high, and not after the second. Holding the pin high after the request has been serviced raises no second request.
- R3: A pending request is reported on `irq_pending_o` only in cycles where `instr_done_i` is 1. In all other cycles the request stays latched.
- R4: When `ack_i` is 1 in a cycle where `irq_pending_o` is 1, the entry takes effect in that cycle. `pc_sel_o` is 1 (vector), `target_pc_o` equals the vector register, the pending flag clears, and `in_service_o` is 1 from the next cycle.
- R5: On an accepted entry, the value on `next_pc_i` is stored as the return address.
- R6: When `reti_i` is 1 while `in_service_o` is 1, `pc_sel_o` is 2 (return) and `target_pc_o` equals the stored return address. `in_service_o` is 0 from the next cycle.
- R7: While `in_service_o` is 1, `irq_pending_o` stays 0 and `ack_i` is ignored. A request that arrives during service stays latched and is reported at the first instruction boundary after the return. The stored return address does not change during service.
- R8: Several rising edges that arrive while a request is already latched merge into that request and cause exactly one entry.
- R9: `reti_i` outside service is ignored: `pc_sel_o` stays 0 and `target_pc_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 1 | Asynchronous external interrupt line |
| instr_done_i | input | 1 | Sequencer is at an instruction boundary |
| ack_i | input | 1 | Sequencer accepts the pending interrupt |
| reti_i | input | 1 | Return-from-interrupt command |
| next_pc_i | input | PC_W | Address of the instruction after the current one |
| irq_pending_o | output | 1 | Interrupt waiting at this boundary |
| in_service_o | output | 1 | Service routine is active |
| pc_sel_o | output | 2 | PC source: 0 next, 1 vector, 2 return |
| target_pc_o | output | PC_W | Vector or return address; 0 when the select is 0 |

## Verification
The bench targets the synchronizer latency by looking for the pending indication one edge too early and exactly on time. It holds the pin high across an entire service to catch a design that triggers on level and would re-enter forever. It sends edges during service and before the first boundary: a design without the in-service gate would overwrite the return address, and one that drops rather than latches those edges would lose an interrupt or take two. Randomized return addresses and service lengths expose a buffer that captures on the wrong cycle, and a stray return command catches a design that jumps to a stale address.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        PC_SEL_NEXT   = 2'd0,
        PC_SEL_VECTOR = 2'd1,
        PC_SEL_RETURN = 2'd2
    } pc_sel_e;

    // Control events produced by the flag logic for the PC path.
    typedef struct packed {
        logic enter;
        logic leave;
    } irq_evt_t;

    function automatic logic rise_of(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

    function automatic pc_sel_e pick_sel(input irq_evt_t evt);
        if (evt.enter)      return PC_SEL_VECTOR;
        else if (evt.leave) return PC_SEL_RETURN;
        else                return PC_SEL_NEXT;
    endfunction

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync
    import irq_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            last_q <= sync_q[TOP];
        end
    end

    assign rise_o = rise_of(sync_q[TOP], last_q);

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rise_i,
    input  logic     instr_done_i,
    input  logic     ack_i,
    input  logic     reti_i,
    output logic     pending_o,
    output logic     in_service_o,
    output irq_evt_t evt_o
);
    logic flag_q;
    logic svc_q;

    always_comb begin
        pending_o   = flag_q & instr_done_i & ~svc_q;
        evt_o.enter = pending_o & ack_i;
        evt_o.leave = svc_q & reti_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            svc_q  <= 1'b0;
        end else begin
            // A fresh edge always wins, so a request in the entry cycle is kept.
            flag_q <= rise_i | (flag_q & ~evt_o.enter);
            if (evt_o.enter)      svc_q <= 1'b1;
            else if (evt_o.leave) svc_q <= 1'b0;
        end
    end

    assign in_service_o = svc_q;

endmodule

// File: rtl/irq_pc_store.sv
module irq_pc_store
    import irq_pkg::*;
#(
    parameter int              PC_W    = 16,
    parameter logic [PC_W-1:0] VEC_RST = 16'h0F80
) (
    input  logic            clk,
    input  logic            rst,
    input  irq_evt_t        evt_i,
    input  logic [PC_W-1:0] next_pc_i,
    output logic [PC_W-1:0] vec_o,
    output logic [PC_W-1:0] ret_pc_o
);
    logic [PC_W-1:0] vec_q;
    logic [PC_W-1:0] ret_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= VEC_RST;
            ret_q <= '0;
        end else if (evt_i.enter) begin
            ret_q <= next_pc_i;
        end
    end

    assign vec_o    = vec_q;
    assign ret_pc_o = ret_q;

endmodule

// File: rtl/irq_unit.sv
module irq_unit
    import irq_pkg::*;
#(
    parameter int              PC_W        = 16,
    parameter int              SYNC_STAGES = 2,
    parameter logic [PC_W-1:0] VEC_RST     = 16'h0F80
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            irq_req_i,
    input  logic            instr_done_i,
    input  logic            ack_i,
    input  logic            reti_i,
    input  logic [PC_W-1:0] next_pc_i,
    output logic            irq_pending_o,
    output logic            in_service_o,
    output logic [1:0]      pc_sel_o,
    output logic [PC_W-1:0] target_pc_o
);
    logic            rise;
    irq_evt_t        evt;
    logic [PC_W-1:0] vec_addr;
    logic [PC_W-1:0] ret_pc;
    pc_sel_e         sel;

    irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (irq_req_i),
        .rise_o  (rise)
    );

    irq_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .rise_i       (rise),
        .instr_done_i (instr_done_i),
        .ack_i        (ack_i),
        .reti_i       (reti_i),
        .pending_o    (irq_pending_o),
        .in_service_o (in_service_o),
        .evt_o        (evt)
    );

    irq_pc_store #(.PC_W(PC_W), .VEC_RST(VEC_RST)) u_store (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt),
        .next_pc_i (next_pc_i),
        .vec_o     (vec_addr),
        .ret_pc_o  (ret_pc)
    );

    always_comb begin
        sel = pick_sel(evt);
        unique case (sel)
            PC_SEL_VECTOR: target_pc_o = vec_addr;
            PC_SEL_RETURN: target_pc_o = ret_pc;
            default:       target_pc_o = '0;
        endcase
    end

    assign pc_sel_o = sel;

endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk #(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            instr_done_i,
    input logic            ack_i,
    input logic            reti_i,
    input logic [PC_W-1:0] next_pc_i,
    input logic            irq_pending_o,
    input logic            in_service_o,
    input logic [1:0]      pc_sel_o,
    input logic [PC_W-1:0] target_pc_o,
    input logic [PC_W-1:0] ret_pc
);
    p_boundary_only_r3: assert property (@(posedge clk) disable iff (rst)
        !instr_done_i |-> !irq_pending_o);

    p_enter_vector_r4: assert property (@(posedge clk) disable iff (rst)
        (irq_pending_o && ack_i) |-> (pc_sel_o == 2'd1));

    p_enter_service_r4: assert property (@(posedge clk) disable iff (rst)
        (irq_pending_o && ack_i) |=> in_service_o);

    p_save_pc_r5: assert property (@(posedge clk) disable iff (rst)
        (irq_pending_o && ack_i) |=> (ret_pc == $past(next_pc_i)));

    p_return_addr_r6: assert property (@(posedge clk) disable iff (rst)
        (in_service_o && reti_i) |-> (pc_sel_o == 2'd2 && target_pc_o == ret_pc));

    p_leave_service_r6: assert property (@(posedge clk) disable iff (rst)
        (in_service_o && reti_i) |=> !in_service_o);

    p_no_reentry_r7: assert property (@(posedge clk) disable iff (rst)
        in_service_o |-> !irq_pending_o);

    p_buf_held_r7: assert property (@(posedge clk) disable iff (rst)
        in_service_o |=> $stable(ret_pc));

    p_idle_next_r9: assert property (@(posedge clk) disable iff (rst)
        (!in_service_o && !(irq_pending_o && ack_i)) |-> (pc_sel_o == 2'd0 && target_pc_o == '0));

    p_legal_sel_r1: assert property (@(posedge clk) disable iff (rst)
        pc_sel_o != 2'd3);

endmodule

bind irq_unit irq_unit_chk #(.PC_W(PC_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .instr_done_i  (instr_done_i),
    .ack_i         (ack_i),
    .reti_i        (reti_i),
    .next_pc_i     (next_pc_i),
    .irq_pending_o (irq_pending_o),
    .in_service_o  (in_service_o),
    .pc_sel_o      (pc_sel_o),
    .target_pc_o   (target_pc_o),
    .ret_pc        (ret_pc)
);

// File: tb/irq_unit_tb.sv
module irq_unit_tb;
    localparam int          PC_W = 16;
    localparam logic [15:0] VEC  = 16'h0F80;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            irq_req_i = 1'b0;
    logic            instr_done_i = 1'b0;
    logic            ack_i = 1'b0;
    logic            reti_i = 1'b0;
    logic [PC_W-1:0] next_pc_i = '0;
    logic            irq_pending_o;
    logic            in_service_o;
    logic [1:0]      pc_sel_o;
    logic [PC_W-1:0] target_pc_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_unit u_dut (
        .clk           (clk),
        .rst           (rst),
        .irq_req_i     (irq_req_i),
        .instr_done_i  (instr_done_i),
        .ack_i         (ack_i),
        .reti_i        (reti_i),
        .next_pc_i     (next_pc_i),
        .irq_pending_o (irq_pending_o),
        .in_service_o  (in_service_o),
        .pc_sel_o      (pc_sel_o),
        .target_pc_o   (target_pc_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse();
        irq_req_i = 1'b1;
        tick();
        irq_req_i = 1'b0;
    endtask

    // Accept at a boundary and check the vector path.
    task automatic enter(input logic [15:0] pc, input string tag);
        instr_done_i = 1'b1;
        next_pc_i    = pc;
        #1;
        check({tag, " R3 pending at boundary"}, irq_pending_o, 1);
        ack_i = 1'b1;
        #1;
        check({tag, " R4 sel vector"}, pc_sel_o, 2'd1);
        check({tag, " R4 vector addr"}, target_pc_o, VEC);
        tick();
        ack_i = 1'b0;
        instr_done_i = 1'b0;
        next_pc_i = '0;
        #1;
        check({tag, " R4 in service"}, in_service_o, 1);
    endtask

    task automatic leave(input logic [15:0] pc, input string tag);
        reti_i = 1'b1;
        #1;
        check({tag, " R6 sel return"}, pc_sel_o, 2'd2);
        check({tag, " R5 R6 return addr"}, target_pc_o, pc);
        tick();
        reti_i = 1'b0;
        #1;
        check({tag, " R6 service ends"}, in_service_o, 0);
    endtask

    function automatic void summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) tick();
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 pending", irq_pending_o, 0);
        check("R1 in_service", in_service_o, 0);
        check("R1 sel", pc_sel_o, 0);
        check("R1 target", target_pc_o, 0);

        // R2 latency, R3 boundary, level held through service
        irq_req_i = 1'b1;
        tick();
        instr_done_i = 1'b1;
        #1 check("R2 not after edge 1", irq_pending_o, 0);
        tick();
        #1 check("R2 not after edge 2", irq_pending_o, 0);
        tick();
        #1 check("R2 pending after edge 3", irq_pending_o, 1);
        instr_done_i = 1'b0;
        #1 check("R3 hidden off boundary", irq_pending_o, 0);
        tick();
        enter(16'h1234, "lvl");
        instr_done_i = 1'b1;
        #1 check("R7 no pending in service", irq_pending_o, 0);
        instr_done_i = 1'b0;
        repeat (2) tick();
        leave(16'h1234, "lvl");
        instr_done_i = 1'b1;
        #1 check("R2 level no retrigger", irq_pending_o, 0);
        instr_done_i = 1'b0;
        irq_req_i = 1'b0;
        repeat (2) tick();

        // R7 request during service, ack ignored, buffer held
        pulse();
        repeat (3) tick();
        enter(16'h2222, "svc");
        pulse();
        repeat (3) tick();
        instr_done_i = 1'b1;
        next_pc_i = 16'h5555;
        ack_i = 1'b1;
        #1;
        check("R7 pending blocked", irq_pending_o, 0);
        check("R7 ack ignored sel", pc_sel_o, 0);
        tick();
        ack_i = 1'b0;
        instr_done_i = 1'b0;
        next_pc_i = '0;
        leave(16'h2222, "svc");
        enter(16'h3333, "after");
        leave(16'h3333, "after");

        // R8 merged edges give one entry
        pulse();
        repeat (5) tick();
        pulse();
        repeat (3) tick();
        enter(16'h4444, "merge");
        leave(16'h4444, "merge");
        instr_done_i = 1'b1;
        #1 check("R8 single entry", irq_pending_o, 0);
        instr_done_i = 1'b0;

        // R9 stray return
        reti_i = 1'b1;
        #1;
        check("R9 sel stays next", pc_sel_o, 0);
        check("R9 target zero", target_pc_o, 0);
        tick();
        reti_i = 1'b0;
        #1 check("R9 no service", in_service_o, 0);

        // Randomized entries and returns
        for (int i = 0; i < 30; i++) begin
            logic [15:0] pc;
            int gap;
            int len;
            pc  = 16'($urandom);
            gap = $urandom_range(0, 4);
            len = $urandom_range(1, 6);
            repeat (gap) tick();
            pulse();
            repeat (3) tick();
            enter(pc, "rnd");
            repeat (len) tick();
            leave(pc, "rnd");
        end

        summary();
        $finish;
    end

endmodule